// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Flag

This block is a digital three-state phase/frequency comparator running on a system clock. It watches two divided edge streams, a reference and a feedback, and for each comparison it drives pump-raise and pump-lower commands for an external charge pump. The command that starts first stays on until the other edge arrives. After that, both commands stay on together for a fixed number of clock cycles before they clear. This forced overlap removes the dead zone near zero phase error.

A polarity input adapts the block to oscillators whose frequency falls as their control voltage rises. A current-magnitude select is passed through to a registered flag. An idle indication shows when the pump output should float. A lock flag follows pump inactivity. A power-down input silences both commands, clears the pending state and holds lock high. The block expects comparison rates of at most 10 MHz, well below the system clock.

Top module: `pfd_lock_top`

## Requirements
- R1: While rst_ni is low, up_o and dn_o are 0, hiz_o and lock_o are 1, and cur4x_o is 0.
- R2: With pol_neg_i=0, a rising edge on ref_i (low at one clock edge, high at the next) sets up_o from that clock edge onward.
- R3: With pol_neg_i=0, a rising edge on fb_i sets dn_o from that clock edge onward.
- R4: Once both pump states are active, both stay active for exactly RST_DLY clock cycles (default 2), and then both clear together.
- R5: With pol_neg_i=0, when ref_i leads fb_i by P cycles, up_o is high for P+RST_DLY cycles and dn_o is high for RST_DLY cycles.
- R6: With pol_neg_i=0, when fb_i leads ref_i by P cycles, dn_o is high for P+RST_DLY cycles and up_o is high for RST_DLY cycles.
- R7: With pol_neg_i=1 (negative oscillator slope), up_o and dn_o exchange roles: the reference-driven state appears on dn_o and the feedback-driven state on up_o.
- R8: hiz_o is 1 exactly when neither up_o nor dn_o is 1.
- R9: lock_o is 0 whenever up_o or dn_o is 1, and 1 otherwise.
- R10: While pdn_i=1, up_o and dn_o are 0 and lock_o is 1. Edges seen during power-down are ignored, and state pending at power-down entry is discarded, so no pulse appears after release.
- R11: cur4x_o (1 = 4x pump current, 0 = 1x) equals cur4x_i as sampled on the previous clock edge.
- R12: Reference and feedback edges that arrive on the same cycle produce an up_o and dn_o pulse of exactly RST_DLY cycles each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | Divided reference pulse stream |
| fb_i | input | 1 | Divided feedback pulse stream |
| pol_neg_i | input | 1 | 1 selects a negative oscillator slope (swaps up_o and dn_o) |
| cur4x_i | input | 1 | 1 selects 4x pump current, 0 selects 1x |
| pdn_i | input | 1 | Power-down |
| up_o | output | 1 | Pump-raise command |
| dn_o | output | 1 | Pump-lower command |
| hiz_o | output | 1 | Pump output floats (no command active) |
| cur4x_o | output | 1 | Registered current-magnitude flag |
| lock_o | output | 1 | Lock indication, high while the pump is idle |

## Verification
If the reset-delay counter is wrong, the overlap window of every comparison gets longer or shorter. So every pulse width is off by a fixed amount on the first comparison. If a pump flop stays set, the lock flag stays low and the idle indication never returns within a few cycles. If a stale state survives power-down, a pulse appears right after release. The bench therefore measures complete pulse widths for leading, lagging and coincident edges in both polarities, and it checks the outputs cycle by cycle around power-down.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int unsigned DEF_RST_DLY = 2;
  localparam int unsigned N_CH = 2;
  localparam int unsigned CH_REF = 0;
  localparam int unsigned CH_FB = 1;

  typedef struct packed {
    logic up;
    logic dn;
  } pump_t;
endpackage

// File: rtl/pfd_edge.sv
module pfd_edge #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] in_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[g] <= 1'b0;
      else         prev_q[g] <= in_i[g];
    end
    assign rise_o[g] = in_i[g] & ~prev_q[g];
  end
endmodule

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_pkg::*;
#(
  parameter int unsigned RST_DLY = DEF_RST_DLY
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  pdn_i,
  input  logic  ref_rise_i,
  input  logic  fb_rise_i,
  output pump_t pump_o
);
  localparam int unsigned CW = (RST_DLY < 2) ? 1 : $clog2(RST_DLY);
  localparam logic [CW-1:0] LAST = CW'(RST_DLY - 1);

  logic          up_q, dn_q;
  logic [CW-1:0] cnt_q;
  logic          both, clr;

  assign both = up_q & dn_q;
  assign clr  = both & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
      cnt_q <= '0;
    end else if (pdn_i) begin
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      // a new edge on the clearing cycle re-arms its side
      up_q  <= (up_q & ~clr) | ref_rise_i;
      dn_q  <= (dn_q & ~clr) | fb_rise_i;
      cnt_q <= (both & ~clr) ? cnt_q + 1'b1 : '0;
    end
  end

  assign pump_o.up = up_q;
  assign pump_o.dn = dn_q;
endmodule

// File: rtl/pfd_drive.sv
module pfd_drive
  import pfd_pkg::*;
(
  input  pump_t pump_i,
  input  logic  pol_neg_i,
  input  logic  pdn_i,
  output logic  up_o,
  output logic  dn_o,
  output logic  hiz_o,
  output logic  lock_o
);
  logic up_s, dn_s;

  always_comb begin
    up_s = pol_neg_i ? pump_i.dn : pump_i.up;
    dn_s = pol_neg_i ? pump_i.up : pump_i.dn;
    if (pdn_i) begin
      up_s = 1'b0;
      dn_s = 1'b0;
    end
  end

  assign up_o   = up_s;
  assign dn_o   = dn_s;
  assign hiz_o  = ~(up_s | dn_s);
  assign lock_o = pdn_i | ~(pump_i.up | pump_i.dn);
endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top
  import pfd_pkg::*;
#(
  parameter int unsigned RST_DLY = DEF_RST_DLY
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  input  logic fb_i,
  input  logic pol_neg_i,
  input  logic cur4x_i,
  input  logic pdn_i,
  output logic up_o,
  output logic dn_o,
  output logic hiz_o,
  output logic cur4x_o,
  output logic lock_o
);
  logic [N_CH-1:0] in_v, rise_v;
  pump_t           pump;
  logic            cur_q;

  assign in_v[CH_REF] = ref_i;
  assign in_v[CH_FB]  = fb_i;

  pfd_edge #(.N(N_CH)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   (in_v),
    .rise_o (rise_v)
  );

  pfd_core #(.RST_DLY(RST_DLY)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pdn_i      (pdn_i),
    .ref_rise_i (rise_v[CH_REF]),
    .fb_rise_i  (rise_v[CH_FB]),
    .pump_o     (pump)
  );

  pfd_drive u_drive (
    .pump_i    (pump),
    .pol_neg_i (pol_neg_i),
    .pdn_i     (pdn_i),
    .up_o      (up_o),
    .dn_o      (dn_o),
    .hiz_o     (hiz_o),
    .lock_o    (lock_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_q <= 1'b0;
    else         cur_q <= cur4x_i;
  end
  assign cur4x_o = cur_q;
endmodule

// File: rtl/pfd_lock_chk.sv
module pfd_lock_chk #(
  parameter int unsigned RST_DLY = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic ref_i,
  input logic fb_i,
  input logic pol_neg_i,
  input logic cur4x_i,
  input logic pdn_i,
  input logic up_o,
  input logic dn_o,
  input logic hiz_o,
  input logic cur4x_o,
  input logic lock_o
);
  logic        both;
  logic [15:0] run_q;

  assign both = up_o & dn_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             run_q <= '0;
    else if (!both)          run_q <= '0;
    else if (run_q != '1)    run_q <= run_q + 1'b1;
  end

  // R2
  ref_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ref_i) && !pdn_i && !pol_neg_i) |=> (up_o || pdn_i || pol_neg_i));

  // R3
  fb_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(fb_i) && !pdn_i && !pol_neg_i) |=> (dn_o || pdn_i || pol_neg_i));

  // R4
  overlap_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= 16'(RST_DLY));

  // R4
  overlap_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(both) && !pdn_i && !$past(pdn_i)) |-> (run_q == 16'(RST_DLY)));

  // R8
  hiz_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hiz_o |-> (!up_o && !dn_o));

  // R9
  lock_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_o || dn_o) |-> !lock_o);

  // R10
  pdn_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdn_i |-> (!up_o && !dn_o && lock_o && hiz_o));

  // R11
  cur_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(cur4x_i) |=> (cur4x_o == $past(cur4x_i)));
endmodule

bind pfd_lock_top pfd_lock_chk #(.RST_DLY(RST_DLY)) u_chk (.*);

// File: tb/sim_pfd_lock_top.sv
`timescale 1ns/1ps
module sim_pfd_lock_top;
  localparam int unsigned DLY = 2;
  localparam int WIN = 16;
  localparam int NV = 7;

  typedef struct packed {
    logic [7:0] ra;
    logic [7:0] fa;
    logic       pol;
    logic [7:0] eu;
    logic [7:0] ed;
  } vec_t;

  localparam vec_t VT [NV] = '{
    '{8'd0, 8'd3, 1'b0, 8'd5, 8'd2},
    '{8'd0, 8'd1, 1'b0, 8'd3, 8'd2},
    '{8'd4, 8'd0, 1'b0, 8'd2, 8'd6},
    '{8'd0, 8'd0, 1'b0, 8'd2, 8'd2},
    '{8'd0, 8'd3, 1'b1, 8'd2, 8'd5},
    '{8'd2, 8'd0, 1'b1, 8'd4, 8'd2},
    '{8'd1, 8'd1, 1'b1, 8'd2, 8'd2}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic ref_i = 0, fb_i = 0, pol_neg_i = 0, cur4x_i = 0, pdn_i = 0;
  logic up_o, dn_o, hiz_o, cur4x_o, lock_o;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  pfd_lock_top #(.RST_DLY(DLY)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ref_i(ref_i), .fb_i(fb_i),
    .pol_neg_i(pol_neg_i), .cur4x_i(cur4x_i), .pdn_i(pdn_i),
    .up_o(up_o), .dn_o(dn_o), .hiz_o(hiz_o), .cur4x_o(cur4x_o), .lock_o(lock_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R1 reset state
    idle(3);
    chk(up_o == 0, "R1 up", up_o, 0);
    chk(dn_o == 0, "R1 dn", dn_o, 0);
    chk(hiz_o == 1, "R1 hiz", hiz_o, 1);
    chk(lock_o == 1, "R1 lock", lock_o, 1);
    chk(cur4x_o == 0, "R1 cur", cur4x_o, 0);
    @(negedge clk); rst_ni = 1;
    idle(2);

    // table: pulse widths over a window
    for (int v = 0; v < NV; v++) begin
      int cu, cd, cb, cl, ch, mx;
      string tg;
      cu = 0; cd = 0; cb = 0; cl = 0; ch = 0;
      pol_neg_i = VT[v].pol;
      if (VT[v].pol)             tg = "R7";
      else if (VT[v].ra < VT[v].fa) tg = "R5";
      else if (VT[v].fa < VT[v].ra) tg = "R6";
      else                       tg = "R12";
      for (int c = 0; c < WIN; c++) begin
        @(negedge clk);
        ref_i = (c == int'(VT[v].ra));
        fb_i  = (c == int'(VT[v].fa));
        #1;
        cu += int'(up_o); cd += int'(dn_o);
        cb += int'(up_o & dn_o); cl += int'(!lock_o); ch += int'(hiz_o);
      end
      mx = (VT[v].eu > VT[v].ed) ? int'(VT[v].eu) : int'(VT[v].ed);
      chk(cu == int'(VT[v].eu), {tg, " up width"}, cu, VT[v].eu);
      chk(cd == int'(VT[v].ed), {tg, " dn width"}, cd, VT[v].ed);
      chk(cb == DLY, "R4 overlap", cb, DLY);
      chk(cl == mx, "R9 lock low", cl, mx);
      chk(ch == WIN - mx, "R8 hiz", ch, WIN - mx);
    end
    pol_neg_i = 0;
    idle(4);

    // R2 / R3 latency
    @(negedge clk); ref_i = 1; #1;
    chk(up_o == 0, "R2 before edge", up_o, 0);
    @(negedge clk); ref_i = 0; #1;
    chk(up_o == 1, "R2 up set", up_o, 1);
    chk(lock_o == 0, "R9 lock low", lock_o, 0);
    @(negedge clk); fb_i = 1; #1;
    @(negedge clk); fb_i = 0; #1;
    chk(dn_o == 1, "R3 dn set", dn_o, 1);
    idle(4);
    chk(!up_o && !dn_o, "R4 cleared", {up_o, dn_o}, 0);

    // R10 power-down discards pending state
    @(negedge clk); ref_i = 1; #1;
    @(negedge clk); ref_i = 0; #1;
    chk(up_o == 1, "R2 up pending", up_o, 1);
    @(negedge clk); pdn_i = 1; #1;
    chk(up_o == 0, "R10 up off", up_o, 0);
    chk(lock_o == 1, "R10 lock", lock_o, 1);
    @(negedge clk); fb_i = 1; #1;
    @(negedge clk); fb_i = 0; #1;
    chk(dn_o == 0, "R10 dn off", dn_o, 0);
    idle(2);
    @(negedge clk); pdn_i = 0;
    idle(4);
    chk(!up_o && !dn_o, "R10 no stale pulse", {up_o, dn_o}, 0);
    chk(lock_o == 1, "R10 lock after", lock_o, 1);

    // R11 current flag
    @(negedge clk); cur4x_i = 1; #1;
    chk(cur4x_o == 0, "R11 before", cur4x_o, 0);
    @(negedge clk); #1;
    chk(cur4x_o == 1, "R11 4x", cur4x_o, 1);
    @(negedge clk); cur4x_i = 0; #1;
    @(negedge clk); #1;
    chk(cur4x_o == 0, "R11 1x", cur4x_o, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule